// File: doc/BRIEF.md
# Burst-to-Continuous Sample Rate Buffer

This block takes left/right audio bit pairs that arrive in short bursts on a fast bit clock and re-emits them as a steady serial stream at one quarter of that rate. It is meant to feed a multibit converter that loads left and right words at the same time. Each sample period opens with a frame pulse. The block accepts the first 16 bit pairs of the period, most significant bit first, and ignores the rest. Each accepted pair goes into a 4-lane elastic store together with a word-boundary marker and a constant-high valid flag, so that the marker and the flag leave the store in step with the data.

The output side holds its divided bit clock low until the store holds 16 entries. After that it pops one entry on every fourth input clock, without a pause. The marker lane becomes the latch-enable output. It is high for the bit period that follows the least significant bit of a word, which is the period carrying the next word's MSB. The MSB can optionally be inverted on the way in, which turns two's complement into offset binary. If the store underflows or overflows, a sticky error flag is set and the output side goes back to waiting for half fill.

Top module: `rbuf_top`

## Requirements
- R1: During and right after reset, bck_o, left_o, right_o, le_o, valid_o and err_o are 0, and fill_o is 0.
- R2: A frame_i pulse opens a sample period. Only the first 16 cycles with bit_valid_i high are stored, counting the frame cycle itself. Later valid cycles in the same period are discarded and never reach the outputs.
- R3: After it has started, bck_o has a period of exactly 4 clk cycles: high for 2 cycles, then low for 2. Each high phase is one output bit.
- R4: bck_o stays low until fill_o has reached 16, which is half of the 32-entry store.
- R5: Stored pairs leave on left_o/right_o in arrival order, one pair per bck_o period. They change only while bck_o is low.
- R6: le_o is high for exactly one output bit: the bit that carries the first stored pair of a period, which follows the LSB of the previous word.
- R7: valid_o is high for every bit emitted from the store, and it stays high without gaps until an error occurs.
- R8: When invert_msb_i is 1, the left and right bits of the first stored pair of each period (the MSB) are inverted. All other bits pass through unchanged.
- R9: With one full burst per 64 clocks, the fill level in steady state rises by exactly 12 over each burst and never reaches 0 or 32.
- R10: A pop from an empty store or a push into a full store sets err_o. err_o then stays set until reset, and the same edge clears valid_o and bck_o and puts the output side back into waiting for half fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input bit clock, 64 times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | One-cycle pulse that opens a sample period |
| bit_valid_i | input | 1 | Marks a cycle that carries an input bit pair |
| left_i | input | 1 | Left channel serial bit |
| right_i | input | 1 | Right channel serial bit |
| invert_msb_i | input | 1 | Inverts the MSB of each stored word |
| bck_o | output | 1 | Divided output bit clock |
| left_o | output | 1 | Left channel output bit |
| right_o | output | 1 | Right channel output bit |
| le_o | output | 1 | Latch-enable lane output |
| valid_o | output | 1 | Valid lane output |
| fill_o | output | 6 | Current store occupancy |
| err_o | output | 1 | Sticky underflow/overflow flag |

## Verification
The assertions assume that bursts arrive no more often than once per 64 clocks, so the store cannot overflow in normal use. They also assume that invert_msb_i changes only between periods. The stimulus keeps to this: it pulses frame_i every 64 clocks and drives up to 20 valid cycles right after each pulse with random bits. It changes the inversion setting only across a reset. The one planned violation comes at the end of a run, when bursts stop so that the store drains and underflows, which tests the error path.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
    typedef struct packed {
        logic valid;
        logic le;
        logic right;
        logic left;
    } lane_t;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/rbuf_store.sv
module rbuf_store
    import rbuf_pkg::*;
#(
    parameter int STAGE_DEPTH = 16,
    parameter int STAGES      = 2,
    localparam int DEPTH      = STAGE_DEPTH * STAGES,
    localparam int AW         = $clog2(DEPTH),
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  lane_t         wdata,
    input  logic          pop,
    output lane_t         rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t  ptr_d, ptr_q;
    lane_t mem [DEPTH];
    logic  do_push, do_pop;
    logic [AW-1:0] wr_next, rd_next;

    assign full    = (ptr_q.cnt == CW'(DEPTH));
    assign empty   = (ptr_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = ptr_q.cnt;
    assign rdata   = mem[ptr_q.rd];

    generate
        if ((1 << AW) == DEPTH) begin : g_wrap_pow2
            assign wr_next = ptr_q.wr + 1'b1;
            assign rd_next = ptr_q.rd + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_next = (ptr_q.wr == AW'(DEPTH - 1)) ? '0 : ptr_q.wr + 1'b1;
            assign rd_next = (ptr_q.rd == AW'(DEPTH - 1)) ? '0 : ptr_q.rd + 1'b1;
        end
    endgenerate

    always_comb begin
        ptr_d = ptr_q;
        if (do_push) ptr_d.wr = wr_next;
        if (do_pop)  ptr_d.rd = rd_next;
        ptr_d.cnt = ptr_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
        if (do_push) mem[ptr_q.wr] <= wdata;
    end
endmodule

// File: rtl/rbuf_writer.sv
module rbuf_writer
    import rbuf_pkg::*;
#(
    parameter int WORD_BITS = 16,
    localparam int IW       = $clog2(WORD_BITS + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame,
    input  logic  bit_valid,
    input  logic  left,
    input  logic  right,
    input  logic  invert_msb,
    output logic  push,
    output lane_t wdata
);
    typedef struct packed {
        logic [IW-1:0] idx;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [IW-1:0] cur;
    logic          is_msb;

    always_comb begin
        st_d   = st_q;
        cur    = frame ? '0 : st_q.idx;
        is_msb = (cur == '0);
        push   = bit_valid && (cur < IW'(WORD_BITS));
        st_d.idx = cur + IW'(push);
        wdata.valid = 1'b1;
        wdata.le    = is_msb;
        wdata.left  = left  ^ (invert_msb && is_msb);
        wdata.right = right ^ (invert_msb && is_msb);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.idx <= IW'(WORD_BITS);
        else        st_q     <= st_d;
    end
endmodule

// File: rtl/rbuf_reader.sv
module rbuf_reader
    import rbuf_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int DIV     = 4,
    localparam int HALF   = DEPTH / 2,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int DW     = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          empty,
    input  lane_t         rdata,
    input  logic          ovf_evt,
    output logic          pop,
    output logic          bck,
    output lane_t         out_lane,
    output logic          err
);
    typedef struct packed {
        rd_state_e     state;
        logic [DW-1:0] div;
        lane_t         out;
        logic          err;
    } rd_t;

    rd_t  r_d, r_q;
    logic tick, udf;

    always_comb begin
        r_d  = r_q;
        tick = (r_q.state == ST_RUN) && (r_q.div == DW'(DIV - 1));
        udf  = tick && empty;
        pop  = tick && !empty;
        if (udf || ovf_evt) begin
            r_d.err   = 1'b1;
            r_d.state = ST_WAIT;
            r_d.div   = '0;
            r_d.out   = '0;
        end else if (r_q.state == ST_WAIT) begin
            if (count >= CW'(HALF)) r_d.state = ST_RUN;
        end else begin
            r_d.div = r_q.div + 1'b1;
            if (tick) r_d.out = rdata;
        end
    end

    assign bck      = (r_q.state == ST_RUN) && (r_q.div >= DW'(DIV / 2));
    assign out_lane = r_q.out;
    assign err      = r_q.err;

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/rbuf_top.sv
module rbuf_top
    import rbuf_pkg::*;
#(
    parameter int WORD_BITS   = 16,
    parameter int STAGE_DEPTH = 16,
    parameter int STAGES      = 2,
    parameter int DIV         = 4,
    localparam int DEPTH      = STAGE_DEPTH * STAGES,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic          bit_valid_i,
    input  logic          left_i,
    input  logic          right_i,
    input  logic          invert_msb_i,
    output logic          bck_o,
    output logic          left_o,
    output logic          right_o,
    output logic          le_o,
    output logic          valid_o,
    output logic [CW-1:0] fill_o,
    output logic          err_o
);
    lane_t wdata, rdata, out_lane;
    logic  push, pop, full, empty;
    logic [CW-1:0] count;

    rbuf_writer #(.WORD_BITS(WORD_BITS)) u_wr (
        .clk(clk), .rst_n(rst_n), .frame(frame_i), .bit_valid(bit_valid_i),
        .left(left_i), .right(right_i), .invert_msb(invert_msb_i),
        .push(push), .wdata(wdata)
    );

    rbuf_store #(.STAGE_DEPTH(STAGE_DEPTH), .STAGES(STAGES)) u_st (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(wdata), .pop(pop),
        .rdata(rdata), .count(count), .full(full), .empty(empty)
    );

    rbuf_reader #(.DEPTH(DEPTH), .DIV(DIV)) u_rd (
        .clk(clk), .rst_n(rst_n), .count(count), .empty(empty), .rdata(rdata),
        .ovf_evt(push && full), .pop(pop), .bck(bck_o), .out_lane(out_lane),
        .err(err_o)
    );

    assign left_o  = out_lane.left;
    assign right_o = out_lane.right;
    assign le_o    = out_lane.le;
    assign valid_o = out_lane.valid;
    assign fill_o  = count;
endmodule

// File: rtl/rbuf_checker.sv
module rbuf_checker #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bck_o,
    input logic          left_o,
    input logic          right_o,
    input logic          le_o,
    input logic          valid_o,
    input logic [CW-1:0] fill_o,
    input logic          err_o
);
    AST_FILL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= CW'(DEPTH)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R10
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!valid_o && !bck_o)); // R10
    AST_LE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        le_o |-> valid_o); // R6
    AST_BCK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n || err_o)
        $rose(bck_o) |=> bck_o); // R3
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bck_o && $past(bck_o)) |-> $stable({left_o, right_o, le_o, valid_o})); // R5
endmodule

bind rbuf_top rbuf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bck_o(bck_o), .left_o(left_o),
    .right_o(right_o), .le_o(le_o), .valid_o(valid_o), .fill_o(fill_o),
    .err_o(err_o)
);

// File: tb/rbuf_top_test.sv
module rbuf_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 64;
    localparam int WORD       = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_i = 1'b0, bit_valid_i = 1'b0, left_i = 1'b0, right_i = 1'b0;
    logic invert_msb_i = 1'b0;
    logic bck_o, left_o, right_o, le_o, valid_o, err_o;
    logic [5:0] fill_o;

    int checks = 0;
    int errors = 0;
    logic [2:0] expq [$];   // {le, right, left}

    always #(CLK_PERIOD / 2) clk = ~clk;

    rbuf_top uut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .bit_valid_i(bit_valid_i),
        .left_i(left_i), .right_i(right_i), .invert_msb_i(invert_msb_i),
        .bck_o(bck_o), .left_o(left_o), .right_o(right_o), .le_o(le_o),
        .valid_o(valid_o), .fill_o(fill_o), .err_o(err_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_entry(input int idx, input logic inv,
                                             input logic l, input logic r);
        logic m;
        m = inv && (idx == 0);
        return {idx == 0, r ^ m, l ^ m};
    endfunction

    // output monitor
    logic prev_bck = 1'b0;
    logic seen_run = 1'b0;
    logic seen_valid = 1'b0;
    int   cyc = 0;
    int   last_rise = -1;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_bck <= 1'b0; seen_run <= 1'b0; seen_valid <= 1'b0; last_rise <= -1;
        end else begin
            cyc <= cyc + 1;
            if (!seen_run && fill_o < 6'd16 && !err_o)
                check(bck_o == 1'b0, "R4 clock before half fill", int'(bck_o), 0);
            if (bck_o) seen_run <= 1'b1;
            if (bck_o && !prev_bck && !err_o) begin
                if (last_rise >= 0)
                    check(cyc - last_rise == 4, "R3 bit clock period", cyc - last_rise, 4);
                last_rise <= cyc;
                if (seen_valid)
                    check(valid_o == 1'b1, "R7 valid lane gap", int'(valid_o), 1);
                if (valid_o) begin
                    seen_valid <= 1'b1;
                    if (expq.size() == 0) begin
                        check(1'b0, "R5 unexpected output bit", 1, 0);
                    end else begin
                        logic [2:0] e;
                        e = expq.pop_front();
                        check({right_o, left_o} == e[1:0], "R5/R8 data order",
                              int'({right_o, left_o}), int'(e[1:0]));
                        check(le_o == e[2], "R6 latch enable position", int'(le_o), int'(e[2]));
                    end
                end
            end
            prev_bck <= bck_o;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frame_i = 1'b0; bit_valid_i = 1'b0;
        expq.delete();
        repeat (3) @(negedge clk);
        check(bck_o == 0 && valid_o == 0 && le_o == 0 && left_o == 0 && right_o == 0,
              "R1 outputs in reset", int'({bck_o, valid_o, le_o, left_o, right_o}), 0);
        check(fill_o == 0 && err_o == 0, "R1 fill and error in reset",
              int'({err_o, fill_o}), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_frame(input int nvalid, input logic inv, output int span, output int lo);
        int mn = 1000, mx = -1;
        for (int c = 0; c < PERIOD; c++) begin
            @(negedge clk);
            if (int'(fill_o) < mn) mn = int'(fill_o);
            if (int'(fill_o) > mx) mx = int'(fill_o);
            frame_i      = (c == 0);
            bit_valid_i  = (c < nvalid);
            left_i       = 1'($urandom);
            right_i      = 1'($urandom);
            invert_msb_i = inv;
            if (c < nvalid && c < WORD)
                expq.push_back(exp_entry(c, inv, left_i, right_i));
        end
        span = mx - mn;
        lo   = mn;
    endtask

    task automatic run_phase(input logic inv, input int frames, input int long_frame);
        int span, lo;
        for (int f = 0; f < frames; f++) begin
            run_frame((f == long_frame) ? WORD + 4 : WORD, inv, span, lo);   // R2 gating
            if (f >= 2) begin
                check(span == 12, "R9 fill swing per period", span, 12);
                check(lo >= 1, "R9 fill minimum above zero", lo, 1);
            end
            check(err_o == 1'b0, "R10 no error in steady state", int'(err_o), 0);
        end
        @(negedge clk);
        frame_i = 1'b0; bit_valid_i = 1'b0;
    endtask

    task automatic drain_and_check();
        repeat (3 * PERIOD) @(negedge clk);
        check(err_o == 1'b1, "R10 underflow sets error", int'(err_o), 1);
        check(valid_o == 1'b0 && bck_o == 1'b0, "R10 outputs idle after error",
              int'({valid_o, bck_o}), 0);
        check(expq.size() == 0, "R5 all stored bits emitted", expq.size(), 0);
        repeat (PERIOD) @(negedge clk);
        check(err_o == 1'b1, "R10 error is sticky", int'(err_o), 1);
    endtask

    initial begin
        void'($urandom(32'd2741));
        do_reset();
        run_phase(1'b0, 10, 4);
        drain_and_check();
        do_reset();
        check(err_o == 1'b0, "R1 reset clears error", int'(err_o), 0);
        run_phase(1'b1, 10, 6);
        drain_and_check();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule